// File: doc/BRIEF.md
# 8x8 Bit-Matrix Multiply Unit

This unit reads each 64-bit operand as a square bit matrix of eight rows, where row k is byte k (bits [8k+7:8k]) and bit c of a row is its column c. It can transpose the first operand. It can also form one of three matrix products of the first operand with the second. The three products differ in how each row-by-column meet is reduced: any bit set (OR of ANDs), all bits set (AND of ANDs), or the parity of the set bits (GF(2) product). In the parity form, each column of the result is further XORed with one bit of an 8-bit constant, which gives a byte affine transform.

A request is the two operands, the constant, an operation code and a valid strobe. The request is evaluated in a single combinational stage. The result is captured in an output register and is presented one cycle later with its own valid flag. The register keeps its value through cycles that carry no request.

Top module: `bmx_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, `res_valid` is 0 and `res_mat` is all zeros.
- R2: `res_valid` is 1 exactly in the cycle after a clock edge at which `req_valid` was 1.
- R3: A clock edge with `req_valid` at 0 leaves `res_mat` unchanged, whatever the other inputs carry.
- R4: Operation code 0 (transpose) puts bit 8r+c of `op_a` at bit 8c+r of `res_mat`. `op_b` and `aff_const` have no effect on this result.
- R5: Operation code 1 (OR product) sets result bit 8r+c when row r of `op_a` and column c of `op_b` share at least one set position k. Row r of `op_a` has bit k at `op_a[8r+k]`, and column c of `op_b` has bit k at `op_b[8k+c]`.
- R6: Operation code 2 (AND product) sets result bit 8r+c only when row r of `op_a` and column c of `op_b` are both 1 at all eight positions k.
- R7: Operation code 3 (affine product) makes result bit 8r+c the parity of the positionwise AND of row r of `op_a` and column c of `op_b`, XORed with bit c of `aff_const`.
- R8: With operation code 3 and `aff_const` at 0, an `op_b` of 0x8040201008040201 returns `op_a` unchanged, and an `op_a` of 0x8040201008040201 returns `op_b` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe; the inputs below are taken on this edge |
| req_op | input | 2 | Operation code: 0 transpose, 1 OR product, 2 AND product, 3 affine product |
| op_a | input | 64 | First matrix (left factor, or the matrix to transpose) |
| op_b | input | 64 | Second matrix (right factor) |
| aff_const | input | 8 | Per-column constant XORed into the affine product |
| res_valid | output | 1 | Result present; high the cycle after a request |
| res_mat | output | 64 | Registered result matrix |

## Verification
The checker takes only one thing for granted about the inputs: the operands and operation code are stable at the clock edge where `req_valid` is sampled. It compares each registered result with the operands captured at that edge. Its properties cover the valid timing, the hold on idle edges, bit-count preservation under transpose, the zero result of an AND product with an empty left factor, and the identity case of the affine product. The bench changes inputs only on falling edges. While `req_valid` is low it drives fresh random operands, so that any leakage into the hold path shows at the output.

// File: rtl/bmx_pkg.sv
package bmx_pkg;

    // Default matrix dimension: rows per operand and bits per row.
    localparam int BMX_DIM = 8;

    typedef enum logic [1:0] {
        BMX_FLIP = 2'd0,
        BMX_ANY  = 2'd1,
        BMX_ALL  = 2'd2,
        BMX_AFF  = 2'd3
    } bmx_op_e;

    // Reduced forms of a single row-by-column meet.
    typedef struct packed {
        logic any_hit;
        logic all_hit;
        logic par_hit;
    } bmx_meet_t;

    // Identity matrix of the given dimension, packed row-major.
    function automatic logic [BMX_DIM*BMX_DIM-1:0] bmx_ident();
        logic [BMX_DIM*BMX_DIM-1:0] m;
        m = '0;
        for (int k = 0; k < BMX_DIM; k++) begin
            m[k*BMX_DIM + k] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/bmx_flip.sv
module bmx_flip #(
    parameter int DIM = bmx_pkg::BMX_DIM,
    localparam int NB = DIM * DIM
) (
    input  logic [NB-1:0] mat_in,
    output logic [NB-1:0] mat_out
);
    // Each output bit at (row, col) takes the input bit at (col, row).
    for (genvar r = 0; r < DIM; r++) begin : g_row
        for (genvar c = 0; c < DIM; c++) begin : g_col
            assign mat_out[r*DIM + c] = mat_in[c*DIM + r];
        end
    end
endmodule

// File: rtl/bmx_meet.sv
module bmx_meet #(
    parameter int DIM = bmx_pkg::BMX_DIM
) (
    input  logic [DIM-1:0]    row_bits,
    input  logic [DIM-1:0]    col_bits,
    output bmx_pkg::bmx_meet_t meet
);
    logic [DIM-1:0] both;

    always_comb begin
        both          = row_bits & col_bits;
        meet.any_hit  = |both;
        meet.all_hit  = &both;
        meet.par_hit  = ^both;
    end
endmodule

// File: rtl/bmx_product.sv
module bmx_product #(
    parameter int DIM = bmx_pkg::BMX_DIM,
    localparam int NB = DIM * DIM
) (
    input  logic [NB-1:0]  lhs,
    input  logic [NB-1:0]  rhs,
    input  logic [DIM-1:0] cval,
    output logic [NB-1:0]  any_mat,
    output logic [NB-1:0]  all_mat,
    output logic [NB-1:0]  aff_mat
);
    // Columns of the right factor become rows of its transpose.
    logic [NB-1:0] rhs_cols;

    bmx_flip #(.DIM(DIM)) u_colgen (
        .mat_in  (rhs),
        .mat_out (rhs_cols)
    );

    for (genvar r = 0; r < DIM; r++) begin : g_row
        for (genvar c = 0; c < DIM; c++) begin : g_col
            bmx_pkg::bmx_meet_t m;

            bmx_meet #(.DIM(DIM)) u_meet (
                .row_bits (lhs[r*DIM +: DIM]),
                .col_bits (rhs_cols[c*DIM +: DIM]),
                .meet     (m)
            );

            assign any_mat[r*DIM + c] = m.any_hit;
            assign all_mat[r*DIM + c] = m.all_hit;
            assign aff_mat[r*DIM + c] = m.par_hit ^ cval[c];
        end
    end
endmodule

// File: rtl/bmx_unit.sv
module bmx_unit #(
    parameter int DIM = bmx_pkg::BMX_DIM,
    localparam int NB = DIM * DIM
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    input  logic [1:0]     req_op,
    input  logic [NB-1:0]  op_a,
    input  logic [NB-1:0]  op_b,
    input  logic [DIM-1:0] aff_const,
    output logic           res_valid,
    output logic [NB-1:0]  res_mat
);
    import bmx_pkg::*;

    bmx_op_e       op_q;
    logic [NB-1:0] flip_mat;
    logic [NB-1:0] any_mat;
    logic [NB-1:0] all_mat;
    logic [NB-1:0] aff_mat;
    logic [NB-1:0] sel_mat;

    assign op_q = bmx_op_e'(req_op);

    bmx_flip #(.DIM(DIM)) u_flip (
        .mat_in  (op_a),
        .mat_out (flip_mat)
    );

    bmx_product #(.DIM(DIM)) u_prod (
        .lhs     (op_a),
        .rhs     (op_b),
        .cval    (aff_const),
        .any_mat (any_mat),
        .all_mat (all_mat),
        .aff_mat (aff_mat)
    );

    always_comb begin
        unique case (op_q)
            BMX_FLIP: sel_mat = flip_mat;
            BMX_ANY:  sel_mat = any_mat;
            BMX_ALL:  sel_mat = all_mat;
            BMX_AFF:  sel_mat = aff_mat;
            default:  sel_mat = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_mat   <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_mat <= sel_mat;
            end
        end
    end
endmodule

// File: rtl/bmx_unit_chk.sv
module bmx_unit_chk #(
    parameter int DIM = bmx_pkg::BMX_DIM,
    localparam int NB = DIM * DIM
) (
    input logic           clk,
    input logic           rst,
    input logic           req_valid,
    input logic [1:0]     req_op,
    input logic [NB-1:0]  op_a,
    input logic [NB-1:0]  op_b,
    input logic [DIM-1:0] aff_const,
    input logic           res_valid,
    input logic [NB-1:0]  res_mat
);
    localparam logic [NB-1:0] IDENT = bmx_pkg::bmx_ident();

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!res_valid && res_mat == '0));

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);

    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !res_valid);

    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(res_mat));

    assert_flip_popcount_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd0) |=>
            ($countones(res_mat) == $countones($past(op_a))));

    assert_all_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd2 && op_a == '0) |=> (res_mat == '0));

    assert_aff_ident_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd3 && aff_const == '0 && op_b == IDENT) |=>
            (res_mat == $past(op_a)));
endmodule

bind bmx_unit bmx_unit_chk #(.DIM(DIM)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .op_a      (op_a),
    .op_b      (op_b),
    .aff_const (aff_const),
    .res_valid (res_valid),
    .res_mat   (res_mat)
);

// File: tb/bmx_unit_test.sv
module bmx_unit_test;
    localparam logic [63:0] IDM = 64'h8040201008040201;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [1:0]  req_op;
    logic [63:0] op_a;
    logic [63:0] op_b;
    logic [7:0]  aff_const;
    logic        res_valid;
    logic [63:0] res_mat;

    int checks = 0;
    int errors = 0;
    logic [63:0] lfsr = 64'h1234_5678_9ABC_DEF1;

    always #5 clk = ~clk;

    bmx_unit uut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (req_op),
        .op_a      (op_a),
        .op_b      (op_b),
        .aff_const (aff_const),
        .res_valid (res_valid),
        .res_mat   (res_mat)
    );

    function automatic logic [63:0] next_rand(input logic [63:0] s);
        logic [63:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    // Reference built from the requirement wording, bit by bit.
    function automatic logic [63:0] model(input logic [1:0] op, input logic [63:0] a,
                                          input logic [63:0] b, input logic [7:0] k);
        logic [63:0] y;
        y = '0;
        for (int r = 0; r < 8; r++) begin
            for (int c = 0; c < 8; c++) begin
                int hits;
                hits = 0;
                for (int p = 0; p < 8; p++) begin
                    if (a[8*r + p] && b[8*p + c]) hits++;
                end
                case (op)
                    2'd0: y[8*c + r] = a[8*r + c];
                    2'd1: y[8*r + c] = (hits != 0);
                    2'd2: y[8*r + c] = (hits == 8);
                    default: y[8*r + c] = hits[0] ^ k[c];
                endcase
            end
        end
        return y;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one request and check the registered result one edge later.
    task automatic issue(input string tag, input logic [1:0] op, input logic [63:0] a,
                         input logic [63:0] b, input logic [7:0] k);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        op_a      = a;
        op_b      = b;
        aff_const = k;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, {63'd0, res_valid}, 64'd1);
        check(tag, res_mat, model(op, a, b, k));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] held;
        rst = 1'b1;
        req_valid = 1'b1;
        req_op = 2'd3;
        op_a = '1;
        op_b = '1;
        aff_const = '1;
        repeat (3) @(negedge clk);
        // R1: reset state, even with a request held high.
        check("R1 valid in reset", {63'd0, res_valid}, 64'd0);
        check("R1 result in reset", res_mat, 64'd0);
        rst = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", {63'd0, res_valid}, 64'd0);
        check("R1 result after reset", res_mat, 64'd0);

        // R4: transpose, with random B and constant that must not matter.
        for (int i = 0; i < 64; i++) begin
            issue("R4 flip onehot", 2'd0, 64'd1 << i, lfsr, lfsr[7:0]);
            lfsr = next_rand(lfsr);
        end
        for (int i = 0; i < 100; i++) begin
            logic [63:0] a;
            a = lfsr;
            lfsr = next_rand(lfsr);
            issue("R4 flip random", 2'd0, a, lfsr, lfsr[15:8]);
            lfsr = next_rand(lfsr);
        end

        // R5, R6, R7: single-bit left factor swept against random right factors.
        for (int op = 1; op < 4; op++) begin
            for (int i = 0; i < 64; i++) begin
                string t;
                t = (op == 1) ? "R5 any onehot" : (op == 2) ? "R6 all onehot" : "R7 aff onehot";
                issue(t, 2'(op), 64'd1 << i, lfsr, lfsr[23:16]);
                lfsr = next_rand(lfsr);
            end
            for (int i = 0; i < 150; i++) begin
                logic [63:0] a;
                string t;
                t = (op == 1) ? "R5 any random" : (op == 2) ? "R6 all random" : "R7 aff random";
                a = lfsr;
                lfsr = next_rand(lfsr);
                // Dense operands make all-ones meets reachable for the AND form.
                if (op == 2 && i[0]) issue(t, 2'(op), a | lfsr, lfsr | (a >> 3), lfsr[7:0]);
                else issue(t, 2'(op), a, lfsr, lfsr[31:24]);
                lfsr = next_rand(lfsr);
            end
        end
        issue("R6 all full", 2'd2, '1, '1, 8'h00);
        issue("R6 all one gap", 2'd2, '1, ~64'h0000_0000_0000_0100, 8'h00);
        issue("R5 any empty", 2'd1, 64'd0, '1, 8'hFF);

        // R7: every constant value with identity right factor.
        for (int k = 0; k < 256; k++) begin
            issue("R7 aff const sweep", 2'd3, lfsr, IDM, 8'(k));
            lfsr = next_rand(lfsr);
        end

        // R8: identity on either side with zero constant.
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            req_valid = 1'b1; req_op = 2'd3; op_a = lfsr; op_b = IDM; aff_const = 8'h00;
            @(negedge clk);
            req_valid = 1'b0;
            check("R8 right identity", res_mat, lfsr);
            lfsr = next_rand(lfsr);
            @(negedge clk);
            req_valid = 1'b1; req_op = 2'd3; op_a = IDM; op_b = lfsr; aff_const = 8'h00;
            @(negedge clk);
            req_valid = 1'b0;
            check("R8 left identity", res_mat, lfsr);
            lfsr = next_rand(lfsr);
        end

        // R2, R3: idle cycles with changing inputs keep the result and drop valid.
        issue("R3 seed", 2'd1, lfsr, next_rand(lfsr), 8'h5A);
        held = res_mat;
        for (int i = 0; i < 20; i++) begin
            lfsr = next_rand(lfsr);
            req_valid = 1'b0;
            req_op = lfsr[1:0];
            op_a = lfsr;
            op_b = ~lfsr;
            aff_const = lfsr[9:2];
            @(negedge clk);
            check("R2 idle valid", {63'd0, res_valid}, 64'd0);
            check("R3 hold", res_mat, held);
        end

        // R2: back-to-back requests keep valid high and update every cycle.
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; op_a = 64'h0123_4567_89AB_CDEF; op_b = '0; aff_const = '0;
        @(negedge clk);
        check("R2 b2b valid 1", {63'd0, res_valid}, 64'd1);
        check("R2 b2b data 1", res_mat, model(2'd0, 64'h0123_4567_89AB_CDEF, '0, '0));
        req_op = 2'd3; op_a = 64'hFFFF_0000_FFFF_0000; op_b = IDM; aff_const = 8'hA5;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 b2b valid 2", {63'd0, res_valid}, 64'd1);
        check("R2 b2b data 2", res_mat, model(2'd3, 64'hFFFF_0000_FFFF_0000, IDM, 8'hA5));
        @(negedge clk);
        check("R2 b2b drop", {63'd0, res_valid}, 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule